// File: doc/BRIEF.md
# Banked Interrupt Status Collector

This block gathers interrupt requests for a host processor. Four pin-bank summary lines and six pulsed peripheral sources are merged into one 10-bit pending word. Each source has its own enable bit, and a single global enable sits above them. Together they drive one registered interrupt line, which the host samples on its rising edge. In its service loop the host reads the pending word and services the banks. It then acknowledges the peripheral bits by writing ones to them, and it repeats this until the word reads zero.

A small register port gives the host access. Requests use a valid/ready handshake: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold a request stable until it is taken. Only reads produce a response. The response sits on `rsp_valid`/`rsp_data` until `rsp_ready` is seen high. While an unconsumed response waits and `rsp_ready` is low, `req_ready` is low, which is how back-pressure reaches the requester.

A run bit in a separate clock-select register powers the collector. While that bit is clear, the collector ignores events and register changes and keeps its interrupt line low.

Top module: `intr_collect`

## Requirements
- R1: After reset the per-source enables, the global enable and the run bit are all 0, `irq` is low, `rsp_valid` is low and `req_ready` is high.
- R2: Status bits 0..3 (address 0) show the bank summary inputs `bank_irq[3:0]` directly, with no latching.
- R3: Status bit 4+i is set by a one-cycle high on `periph_pulse[i]` and stays set until a write to address 0 carries a 1 in that bit. Zeros written to bits 4..9 and any value written to bits 0..3 change nothing.
- R4: When a pulse and a clearing write hit the same peripheral bit in the same cycle, the bit stays set.
- R5: The mask register (address 1) has a per-source enable in bits 0..9, where 1 enables the source, and a global enable in bit 15. It reads back as written.
- R6: `irq` is high one cycle after a cycle in which the run bit and the global enable are set and at least one status bit has its enable set. Otherwise it is low in the following cycle, so it falls once all enabled pending bits are gone.
- R7: Any write accepted at address 0 while running forces `irq` low in the next cycle. The line then re-evaluates, so a source still pending gives a fresh rising edge.
- R8: The clock-select register (address 2) has the run bit in bit 0. It is always writable and readable. While the run bit is 0, pulses are not latched, writes to addresses 0 and 1 are ignored, addresses 0 and 1 read as 0, and `irq` is low.
- R9: Read data is taken from the state at the accepting edge. The response appears in the next cycle and holds stable until `rsp_ready` is high. Reads of address 3 return 0, and writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_irq | input | 4 | Pin-bank summary interrupt levels |
| periph_pulse | input | 6 | One-cycle event pulses from peripheral sources |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 status, 1 mask, 2 clock-select, 3 unused |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | 16 | Read response data |
| irq | output | 1 | Interrupt to host, registered |

## Verification
Two functions can collide in one cycle, and the bench provokes both collisions directly.

- A peripheral event and the host's clearing write can land on the same status bit. The bench drives a pulse in the same cycle as a write that clears that bit, then judges by reading the bit back set.
- The re-arm drop on a status write can meet a still-pending source. The bench checks that `irq` goes low for exactly one cycle and then rises again.

A random phase overlaps pulses, acknowledges, mask and run-bit writes and response back-pressure on every cycle. A cycle-level model, built from the requirements, judges `irq`, `req_ready` and every response in that phase.

// File: rtl/intr_collect_pkg.sv
package intr_collect_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CLKSEL = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_collect_port.sv
module intr_collect_port
  import intr_collect_pkg::*;
#(
  parameter int NUM_SRC    = 10,
  parameter int DATA_W     = 16,
  parameter int GLOBAL_BIT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] src_en,
  output logic               glob_en,
  output logic               run,
  output logic [NUM_SRC-1:0] ack_bits,
  output logic               status_wr
);
  logic               take, wr_take, rd_take;
  reg_sel_e           sel;
  logic [DATA_W-1:0]  rd_val;
  logic [NUM_SRC-1:0] en_q;
  logic               glob_q, run_q, rv_q;
  logic [DATA_W-1:0]  rd_q;

  assign sel       = reg_sel_e'(req_addr);
  assign req_ready = ~rv_q | rsp_ready;
  assign take      = req_valid & req_ready;
  assign wr_take   = take & req_write;
  assign rd_take   = take & ~req_write;
  assign status_wr = wr_take & (sel == SEL_STATUS) & run_q;
  assign ack_bits  = status_wr ? req_wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_STATUS: if (run_q) rd_val[NUM_SRC-1:0] = status;
      SEL_MASK: if (run_q) begin
        rd_val[NUM_SRC-1:0] = en_q;
        rd_val[GLOBAL_BIT]  = glob_q;
      end
      SEL_CLKSEL: rd_val[0] = run_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      glob_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_take && sel == SEL_MASK && run_q) begin
        en_q   <= req_wdata[NUM_SRC-1:0];
        glob_q <= req_wdata[GLOBAL_BIT];
      end
      if (wr_take && sel == SEL_CLKSEL) run_q <= req_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else if (rd_take) begin
      rv_q <= 1'b1;
      rd_q <= rd_val;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign src_en    = en_q;
  assign glob_en   = glob_q;
  assign run       = run_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_ready) |=> (rv_q && $stable(rd_q))); // R9
  AST_NO_ACCEPT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_ready) |-> !req_ready); // R9
endmodule

// File: rtl/intr_collect_pend.sv
module intr_collect_pend #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  localparam int NUM_SRC   = NUM_BANKS + NUM_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [NUM_BANKS-1:0]  bank_irq,
  input  logic [NUM_PERIPH-1:0] periph_pulse,
  input  logic [NUM_SRC-1:0]    ack_bits,
  output logic [NUM_SRC-1:0]    status
);
  logic [NUM_PERIPH-1:0] held;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_src
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bit_q <= 1'b0;
      else if (run) bit_q <= periph_pulse[i] | (bit_q & ~ack_bits[NUM_BANKS+i]);
    end
    assign held[i] = bit_q;
  end

  assign status = {held, bank_irq};

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(held)); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ((held & $past(periph_pulse)) == $past(periph_pulse))); // R4
endmodule

// File: rtl/intr_collect_out.sv
module intr_collect_out #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               glob_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] status,
  input  logic               rearm,
  output logic               irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= run & glob_en & (|(status & src_en)) & ~rearm;
  end

  assign irq = irq_q;

  AST_REARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !irq_q); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq_q); // R8
endmodule

// File: rtl/intr_collect.sv
module intr_collect #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16,
  parameter int GLOBAL_BIT = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BANKS-1:0]  bank_irq,
  input  logic [NUM_PERIPH-1:0] periph_pulse,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  irq
);
  localparam int NUM_SRC = NUM_BANKS + NUM_PERIPH;

  logic [NUM_SRC-1:0] status, src_en, ack_bits;
  logic               glob_en, run, status_wr;

  intr_collect_port #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GLOBAL_BIT(GLOBAL_BIT)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .status(status), .src_en(src_en), .glob_en(glob_en), .run(run),
    .ack_bits(ack_bits), .status_wr(status_wr)
  );

  intr_collect_pend #(
    .NUM_BANKS(NUM_BANKS), .NUM_PERIPH(NUM_PERIPH)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .run(run),
    .bank_irq(bank_irq), .periph_pulse(periph_pulse),
    .ack_bits(ack_bits), .status(status)
  );

  intr_collect_out #(
    .NUM_SRC(NUM_SRC)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .glob_en(glob_en),
    .src_en(src_en), .status(status), .rearm(status_wr), .irq(irq)
  );
endmodule

// File: tb/intr_collect_tb_top.sv
module intr_collect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_irq = '0;
  logic [5:0]  periph_pulse = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [15:0] rsp_data;

  int checks = 0, fails = 0;
  bit running = 0, done = 0;

  always #10 clk = ~clk;

  intr_collect dut_i (
    .clk(clk), .rst_n(rst_n), .bank_irq(bank_irq), .periph_pulse(periph_pulse),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic [5:0]  m_per = '0;
  logic [9:0]  m_en = '0;
  logic        m_glob = 0, m_run = 0, m_irq = 0, m_rspv = 0, m_acc = 0;
  logic [15:0] m_rspd = '0;

  function automatic logic [15:0] exp_read(input logic [1:0] a, input logic [9:0] st);
    case (a)
      2'd0: return m_run ? {6'b0, st} : 16'h0;
      2'd1: return m_run ? {m_glob, 5'b0, m_en} : 16'h0;
      2'd2: return {15'b0, m_run};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic acc, rearm, nirq;
    logic [9:0] st;
    logic [15:0] rv;
    if (!rst_n) begin
      m_per = '0; m_en = '0; m_glob = 0; m_run = 0;
      m_irq = 0; m_rspv = 0; m_rspd = '0; m_acc = 0;
    end else begin
      acc   = req_valid && (!m_rspv || rsp_ready);
      st    = {m_per, bank_irq};
      rv    = exp_read(req_addr, st);
      rearm = acc && req_write && req_addr == 2'd0 && m_run;
      nirq  = m_run && m_glob && (|(st & m_en)) && !rearm;
      if (m_run) m_per = periph_pulse | (m_per & ~(rearm ? req_wdata[9:4] : 6'b0));
      if (acc && req_write && req_addr == 2'd1 && m_run) begin
        m_en = req_wdata[9:0]; m_glob = req_wdata[15];
      end
      if (acc && req_write && req_addr == 2'd2) m_run = req_wdata[0];
      if (acc && !req_write) begin m_rspv = 1; m_rspd = rv; end
      else if (rsp_ready) m_rspv = 0;
      m_irq = nirq;
      m_acc = acc;
    end
  end

  always begin
    @(negedge clk);
    #8;
    if (running) begin
      chk("R6 irq vs model", {15'b0, irq}, {15'b0, m_irq});
      chk("R9 req_ready", {15'b0, req_ready}, {15'b0, (!m_rspv || rsp_ready)});
      chk("R9 rsp_valid", {15'b0, rsp_valid}, {15'b0, m_rspv});
      if (m_rspv) chk("R9 rsp_data", rsp_data, m_rspd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    periph_pulse = 6'(1 << idx);
    @(negedge clk);
    periph_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    #45 rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", {15'b0, irq}, 16'h0);
    chk("R1 rsp_valid after reset", {15'b0, rsp_valid}, 16'h0);
    chk("R1 req_ready after reset", {15'b0, req_ready}, 16'h1);
    running = 1;
    rd(2'd2, d); chk("R1 run bit reset", d, 16'h0);

    bank_irq = 4'b0101;
    pulse(0);
    wr(2'd1, 16'hFFFF);
    rd(2'd0, d); chk("R8 status reads zero while off", d, 16'h0);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); chk("R8 run bit readable", d, 16'h1);
    rd(2'd1, d); chk("R8 mask write ignored while off", d, 16'h0);
    rd(2'd0, d); chk("R8 pulse ignored while off; R2 banks", d, 16'h0005);

    bank_irq = 4'b1010;
    rd(2'd0, d); chk("R2 bank bits follow lines", d, 16'h000A);
    pulse(2);
    rd(2'd0, d); chk("R3 pulse latches bit 6", d, 16'h004A);
    wr(2'd0, 16'h000F);
    rd(2'd0, d); chk("R3 bank-bit and zero writes no effect", d, 16'h004A);
    wr(2'd0, 16'h0040);
    rd(2'd0, d); chk("R3 write one clears", d, 16'h000A);

    bank_irq = 4'b0000;
    wr(2'd1, 16'h8010);
    rd(2'd1, d); chk("R5 mask readback", d, 16'h8010);
    pulse(0);
    idle(2);
    chk("R6 irq asserted", {15'b0, irq}, 16'h1);
    wr(2'd1, 16'h0010);
    idle(1);
    chk("R5 global enable gates irq", {15'b0, irq}, 16'h0);
    wr(2'd1, 16'h8010);
    idle(2);
    chk("R6 irq back with global", {15'b0, irq}, 16'h1);

    wr(2'd0, 16'h0000);
    chk("R7 irq dropped after status write", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R7 irq re-rises while pending", {15'b0, irq}, 16'h1);

    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 2'd0; req_wdata = 16'h0010; periph_pulse = 6'b000001;
    @(negedge clk);
    req_valid = 0; periph_pulse = '0;
    rd(2'd0, d); chk("R4 event wins over clear", d, 16'h0010);
    wr(2'd0, 16'h0010);
    idle(2);
    chk("R6 irq low once cleared", {15'b0, irq}, 16'h0);

    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 2'd1;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R9 response held", rsp_data, 16'h8010);
      chk("R9 ready low while blocked", {15'b0, req_ready}, 16'h0);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    rd(2'd3, d); chk("R9 spare address reads zero", d, 16'h0);

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      bank_irq     = 4'($urandom);
      periph_pulse = ($urandom % 3 == 0) ? 6'($urandom) : 6'b0;
      rsp_ready    = ($urandom % 4 != 0);
      if (!(req_valid && !m_acc)) begin
        req_valid = ($urandom % 3 == 0);
        req_write = $urandom % 2;
        req_addr  = 2'($urandom);
        req_wdata = 16'($urandom);
        if (req_addr == 2'd2) req_wdata[0] = ($urandom % 8 != 0);
      end
    end
    @(negedge clk);
    req_valid = 0; rsp_ready = 1;
    idle(3);
    running = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule